// File: doc/BRIEF.md
# Fiber link integrity monitor

This block watches the receive line of a 10 Mb/s fiber port whose logic runs from an 80 MHz sample clock. Between packets the far end sends a continuous idle waveform at 1 MHz, so a healthy line changes level roughly every 40 sample clocks. The monitor measures the number of clocks between successive level changes and rates each interval as valid or invalid. A long enough run of valid intervals brings the link up. A run of invalid intervals, or a long silence, takes it down. The block comes out of reset with the link down.

A Manchester decoder elsewhere in the port supplies `in_packet`, which is high while a frame is being received. While it is high the link test is suspended: edges are not rated, the silence timer is held at zero, and the state and run counts keep their values. The first level change after reset or after a packet only sets the timing reference and is not rated. The monitor also drives `carrier`, which covers the frame and is stretched past its end to cover the start-of-idle marker.

The control is a two-state machine. In `LINK_FAIL` the transition *recover* to `LINK_UP` fires on the `PASS_RUN`-th consecutive valid interval. In `LINK_UP` the transition *run_fail* to `LINK_FAIL` fires on the `FAIL_RUN`-th consecutive invalid interval, and *silence_fail* fires when `SILENCE_CLKS` clocks pass outside a packet with no edge. Both transitions out of `LINK_UP` clear the run counts.

Top module: `fiber_link_monitor`

## Requirements
- R1: After reset `link_ok` is 0 (state `LINK_FAIL`) and `carrier` is 0.
- R2: An edge is rated valid when the interval since the previous edge is between `GAP_MIN` (30) and `GAP_MAX` (50) clocks inclusive, and invalid otherwise. With default parameters, 29 and 51 are invalid and 30 and 50 are valid.
- R3: The first edge after reset or after `in_packet` falls only sets the timing reference and is not rated.
- R4: In `LINK_FAIL`, `link_ok` rises right after the clock edge that samples the `PASS_RUN`-th (16) consecutive valid interval. An invalid interval or a silence timeout restarts the count.
- R5: In `LINK_UP`, `link_ok` falls right after the `FAIL_RUN`-th (8) consecutive invalid interval. A valid interval restarts the count.
- R6: In `LINK_UP`, if the sampled edge-to-edge count reaches `SILENCE_CLKS` (200) outside a packet with no edge, `link_ok` falls. With the last edge sampled at rising edge t, `link_ok` is still 1 after edge t+199 and is 0 after edge t+200.
- R7: While `in_packet` is high, `link_ok` does not change, and edges and elapsed time are not counted toward any transition.
- R8: `carrier` is 1 from the clock after `in_packet` is first sampled high until `SOI_CLKS` (16) clocks after the last sample of `in_packet` high. Otherwise it is 0.
- R9: Each output is registered once. A change on `rx_line` or `in_packet` sampled at one rising edge is seen on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock (nominally 80 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Raw receive line, already synchronous to `clk` |
| in_packet | input | 1 | High while the decoder is receiving a frame |
| link_ok | output | 1 | 1 in `LINK_UP`, 0 in `LINK_FAIL` |
| carrier | output | 1 | Carrier sense covering the frame plus the start-of-idle tail |

## Verification
The assertions assume that `rx_line` and `in_packet` are already synchronous to `clk` and stable around each rising edge, and that `in_packet` comes from a decoder that raises it only while a frame is present. The bench changes both inputs one time unit after a rising edge and compares outputs at the falling edge, so every value is sampled cleanly. It drives `rx_line` toggles at chosen intervals to produce exactly the sampled gaps that the requirements name. Every clock is also compared against a behavioural reference model.

// File: rtl/flm_pkg.sv
package flm_pkg;

    typedef enum logic {
        LINK_FAIL = 1'b0,
        LINK_UP   = 1'b1
    } link_state_e;

    // Per-clock rating of the idle waveform, produced by the edge timer.
    typedef struct packed {
        logic valid;    // rated edge, interval inside the window
        logic invalid;  // rated edge, interval outside the window
        logic timeout;  // silence limit reached with no edge
    } idle_evt_t;

endpackage

// File: rtl/flm_edge_timer.sv
module flm_edge_timer
    import flm_pkg::*;
#(
    parameter int GAP_MIN      = 30,
    parameter int GAP_MAX      = 50,
    parameter int SILENCE_CLKS = 200
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_line,
    input  logic      in_packet,
    output idle_evt_t evt
);

    localparam int GW = $clog2(SILENCE_CLKS + 1);
    localparam logic [GW-1:0] MIN_C = GW'(GAP_MIN);
    localparam logic [GW-1:0] MAX_C = GW'(GAP_MAX);
    localparam logic [GW-1:0] SIL_C = GW'(SILENCE_CLKS);
    localparam logic [GW-1:0] ONE_C = GW'(1);

    logic          rx_q;
    logic [GW-1:0] gap;
    logic          have_ref;
    logic          edge_seen;
    logic          rated;
    logic          in_window;

    always_comb begin
        edge_seen   = rx_line ^ rx_q;
        rated       = edge_seen && !in_packet && have_ref;
        in_window   = (gap >= MIN_C) && (gap <= MAX_C);
        evt.valid   = rated && in_window;
        evt.invalid = rated && !in_window;
        evt.timeout = !in_packet && !edge_seen && (gap == SIL_C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q     <= 1'b0;
            gap      <= '0;
            have_ref <= 1'b0;
        end else begin
            rx_q <= rx_line;
            if (in_packet) begin
                gap      <= '0;
                have_ref <= 1'b0;
            end else if (edge_seen) begin
                gap      <= ONE_C;
                have_ref <= 1'b1;
            end else if (gap != SIL_C) begin
                gap <= gap + ONE_C;
            end
        end
    end

    // R3: the edge right after a packet sample is never rated
    a_r3_ref_after_packet: assert property (@(posedge clk) disable iff (!rst_n)
        in_packet |=> !(evt.valid || evt.invalid));

    // R2: rating happens only on a sampled level change
    a_r2_rate_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.valid || evt.invalid) |-> (rx_line != $past(rx_line)));

endmodule

// File: rtl/flm_link_fsm.sv
module flm_link_fsm
    import flm_pkg::*;
#(
    parameter int PASS_RUN = 16,
    parameter int FAIL_RUN = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  idle_evt_t evt,
    output logic      link_ok
);

    localparam int PW = $clog2(PASS_RUN + 1);
    localparam int FW = $clog2(FAIL_RUN + 1);
    localparam logic [PW-1:0] PASS_LAST = PW'(PASS_RUN - 1);
    localparam logic [FW-1:0] FAIL_LAST = FW'(FAIL_RUN - 1);

    link_state_e   state, state_n;
    logic [PW-1:0] good, good_n;
    logic [FW-1:0] bad, bad_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LINK_FAIL;
            good  <= '0;
            bad   <= '0;
        end else begin
            state <= state_n;
            good  <= good_n;
            bad   <= bad_n;
        end
    end

    // Transitions
    always_comb begin
        state_n = state;
        good_n  = good;
        bad_n   = bad;
        unique case (state)
            LINK_FAIL: begin
                if (evt.valid) begin
                    if (good == PASS_LAST) begin
                        state_n = LINK_UP;   // recover
                        good_n  = '0;
                        bad_n   = '0;
                    end else begin
                        good_n = good + PW'(1);
                    end
                end else if (evt.invalid || evt.timeout) begin
                    good_n = '0;
                end
            end
            LINK_UP: begin
                if (evt.invalid) begin
                    if (bad == FAIL_LAST) begin
                        state_n = LINK_FAIL; // run_fail
                        good_n  = '0;
                        bad_n   = '0;
                    end else begin
                        bad_n = bad + FW'(1);
                    end
                end else if (evt.valid) begin
                    bad_n = '0;
                end else if (evt.timeout) begin
                    state_n = LINK_FAIL;     // silence_fail
                    good_n  = '0;
                    bad_n   = '0;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        link_ok = (state == LINK_UP);
    end

    // R4: link only comes up on a valid interval
    a_r4_rise_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_ok) |-> $past(evt.valid));

    // R5 / R6: link only drops on an invalid interval or a silence timeout
    a_r5_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_ok) |-> ($past(evt.invalid) || $past(evt.timeout)));

endmodule

// File: rtl/flm_carrier_stretch.sv
module flm_carrier_stretch #(
    parameter int SOI_CLKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_packet,
    output logic carrier
);

    localparam int TW = $clog2(SOI_CLKS + 1);
    localparam logic [TW-1:0] TAIL_FULL = TW'(SOI_CLKS);

    logic [TW-1:0] tail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tail <= '0;
        end else if (in_packet) begin
            tail <= TAIL_FULL;
        end else if (tail != '0) begin
            tail <= tail - TW'(1);
        end
    end

    always_comb begin
        carrier = (tail != '0);
    end

    // R8: carrier follows a frame on the next clock
    a_r8_carrier_on: assert property (@(posedge clk) disable iff (!rst_n)
        in_packet |=> carrier);

    // R8: with no frame, carrier cannot restart by itself
    a_r8_carrier_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!carrier && !in_packet) |=> !carrier);

endmodule

// File: rtl/fiber_link_monitor.sv
module fiber_link_monitor
    import flm_pkg::*;
#(
    parameter int GAP_MIN      = 30,
    parameter int GAP_MAX      = 50,
    parameter int SILENCE_CLKS = 200,
    parameter int PASS_RUN     = 16,
    parameter int FAIL_RUN     = 8,
    parameter int SOI_CLKS     = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_line,
    input  logic in_packet,
    output logic link_ok,
    output logic carrier
);

    idle_evt_t evt;

    flm_edge_timer #(
        .GAP_MIN      (GAP_MIN),
        .GAP_MAX      (GAP_MAX),
        .SILENCE_CLKS (SILENCE_CLKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_line   (rx_line),
        .in_packet (in_packet),
        .evt       (evt)
    );

    flm_link_fsm #(
        .PASS_RUN (PASS_RUN),
        .FAIL_RUN (FAIL_RUN)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .link_ok (link_ok)
    );

    flm_carrier_stretch #(
        .SOI_CLKS (SOI_CLKS)
    ) u_crs (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_packet (in_packet),
        .carrier   (carrier)
    );

    // R7: link state is frozen across a frame
    a_r7_link_hold: assert property (@(posedge clk) disable iff (!rst_n)
        in_packet |=> (link_ok == $past(link_ok)));

endmodule

// File: tb/fiber_link_monitor_test.sv
module fiber_link_monitor_test;

    localparam int GAP_MIN = 30;
    localparam int GAP_MAX = 50;
    localparam int SIL     = 200;
    localparam int PASS    = 16;
    localparam int FAILN   = 8;
    localparam int SOI     = 16;

    logic clk = 1'b0, rst_n = 1'b0, rx = 1'b0, pkt = 1'b0;
    logic link_ok, carrier;

    always #5 clk = ~clk;

    fiber_link_monitor uut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx), .in_packet(pkt),
        .link_ok(link_ok), .carrier(carrier)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // Behavioural reference model
    bit m_prev, m_ref, m_up;
    int m_gap, m_good, m_bad, m_tail;

    always @(posedge clk) begin
        bit e, rated, ok, tmo;
        if (!rst_n) begin
            m_prev = 0; m_ref = 0; m_up = 0;
            m_gap = 0; m_good = 0; m_bad = 0; m_tail = 0;
        end else begin
            e     = (rx != m_prev);
            rated = e && !pkt && m_ref;
            ok    = (m_gap >= GAP_MIN) && (m_gap <= GAP_MAX);
            tmo   = !pkt && !e && (m_gap == SIL);
            if (!m_up) begin
                if (rated && ok) begin
                    m_good++;
                    if (m_good == PASS) begin m_up = 1; m_good = 0; m_bad = 0; end
                end else if ((rated && !ok) || tmo) m_good = 0;
            end else begin
                if (rated && !ok) begin
                    m_bad++;
                    if (m_bad == FAILN) begin m_up = 0; m_good = 0; m_bad = 0; end
                end else if (rated && ok) m_bad = 0;
                else if (tmo) begin m_up = 0; m_good = 0; m_bad = 0; end
            end
            if (pkt) begin m_gap = 0; m_ref = 0; end
            else if (e) begin m_gap = 1; m_ref = 1; end
            else if (m_gap < SIL) m_gap++;
            m_prev = rx;
            if (pkt) m_tail = SOI;
            else if (m_tail > 0) m_tail--;
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
        end
    endtask

    // R9: every clock, outputs equal the model right after the sampling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R9 link_ok vs model", link_ok, m_up);
            chk("R9 carrier vs model", carrier, m_tail > 0);
        end
    end

    task automatic pulse(int n);
        repeat (n) @(posedge clk);
        #1 rx = ~rx;
    endtask

    task automatic train(int n, int cnt);
        repeat (cnt) pulse(n);
    endtask

    task automatic peek();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 link_ok after reset", link_ok, 1'b0);
        chk("R1 carrier after reset", carrier, 1'b0);

        // R3 reference edge, then 15 rated valid intervals
        pulse(40);
        train(40, 15);
        peek();
        chk("R3 R4 up not before 16 rated", link_ok, 1'b0);
        pulse(39);
        peek();
        chk("R4 up after 16 valid", link_ok, 1'b1);

        // R5 with gap 29 (R2 lower bound invalid)
        pulse(28);
        train(29, 6);
        peek();
        chk("R5 still up after 7 invalid", link_ok, 1'b1);
        pulse(28);
        peek();
        chk("R5 down after 8 invalid", link_ok, 1'b0);

        // R2 boundaries 30 and 50 are valid
        pulse(29);
        for (int i = 1; i < 15; i++) pulse((i % 2) ? 50 : 30);
        peek();
        chk("R2 15 boundary intervals", link_ok, 1'b0);
        pulse(49);
        peek();
        chk("R2 up on 30/50 intervals", link_ok, 1'b1);

        // R2 51 invalid; R5 a valid interval restarts the run
        pulse(50);
        train(51, 6);
        pulse(50);
        train(51, 7);
        peek();
        chk("R5 run restarted by valid", link_ok, 1'b1);
        pulse(50);
        peek();
        chk("R2 R5 down on 51 intervals", link_ok, 1'b0);

        pulse(39);
        train(40, 15);
        peek();
        chk("R4 recovered", link_ok, 1'b1);

        // R6 silence limit
        repeat (199) @(posedge clk);
        @(negedge clk);
        chk("R6 up at 199 silent", link_ok, 1'b1);
        peek();
        chk("R6 down at 200 silent", link_ok, 1'b0);

        pulse(40);
        train(40, 16);
        peek();
        chk("R4 recovered after silence", link_ok, 1'b1);

        // R7 / R8 frame
        @(posedge clk);
        #1 pkt = 1'b1;
        peek();
        chk("R8 carrier on", carrier, 1'b1);
        train(5, 60);
        repeat (250) @(posedge clk);
        @(negedge clk);
        chk("R7 link held in packet", link_ok, 1'b1);
        chk("R8 carrier held", carrier, 1'b1);
        @(posedge clk);
        #1 pkt = 1'b0;
        repeat (15) @(posedge clk);
        @(negedge clk);
        chk("R8 carrier in tail", carrier, 1'b1);
        peek();
        chk("R8 carrier off after tail", carrier, 1'b0);

        // R3 first edge after frame is reference only
        pulse(3);
        peek();
        chk("R3 post-packet edge unrated", link_ok, 1'b1);
        pulse(39);
        train(40, 8);
        peek();
        chk("R7 link kept after packet", link_ok, 1'b1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL R9 watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule